// File: doc/BRIEF.md
# Asynchronous Schedule Park Counter

This block limits how many transactions in a row the host controller runs from one high-speed queue head on the asynchronous list. When that limit is reached, it tells the list walker to move on to the next entry. Software sets the limit through two fields of the command word: a park-enable bit and a 2-bit park count. A capability strap decides whether these fields exist. When the strap is off, both fields read as zero and ignore writes. When the strap is on, they reset to enabled with a count of three.

The walker reports three things to the block: each finished transaction (`xact_done_i`), whether the current queue head is high-speed (`qh_hs_i`), and each move to a new queue head (`qh_new_i`). The block answers with a one-cycle advance request, `qh_advance_o`, in the cycle after the transaction that uses up the allowance. All pins are plain control and status pins. Nothing flows in a stream and there is no back-pressure. The walker is expected to act on every advance pulse.

Top module: `park_sched_ctrl`

## Requirements
- R1: After reset with `park_cap_i`=1, `park_en_o` reads 1 and `park_cnt_o` reads 3.
- R2: With `park_cap_i`=0, `park_en_o` and `park_cnt_o` read 0 and command writes have no effect on them.
- R3: With `park_cap_i`=1, a write (`cmd_wr_i`=1) loads the enable from bit 11 and the count from bits 9:8 of `cmd_wdata_i`. Both are visible from the next cycle. Other bits are ignored.
- R4: A write whose count field (bits 9:8) is 0 leaves the stored count unchanged, while the enable bit of that write is still applied. The count therefore never reads 0 while the strap is 1.
- R5: When park mode is off, or `qh_hs_i`=0, every `xact_done_i` pulse gives `qh_advance_o`=1 in the next cycle.
- R6: With park mode on and `qh_hs_i`=1, an advance follows the Nth consecutive completed transaction on a queue head, where N is the park count. The earlier ones give no advance. After an advance the tally restarts.
- R7: `qh_new_i` clears the tally. A `xact_done_i` in the same cycle counts as the first transaction of the new queue head.
- R8: If the count is lowered to N or below after N or more transactions on the current head, the next completed transaction advances.
- R9: `qh_advance_o` is a one-cycle pulse and is 1 only in the cycle after an `xact_done_i`.
- R10: A write in the same cycle as `xact_done_i` takes effect after that transaction. The transaction is judged with the old enable and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| park_cap_i | input | 1 | Park capability strap, held static |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 16 | Command word write data |
| xact_done_i | input | 1 | One pulse per finished transaction |
| qh_hs_i | input | 1 | Current queue head is high-speed |
| qh_new_i | input | 1 | Walker has moved to a new queue head |
| park_en_o | output | 1 | Park enable read-back |
| park_cnt_o | output | 2 | Park count read-back |
| qh_advance_o | output | 1 | Request to move to the next queue head |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes each one.

The first pair is a move to a new queue head together with a transaction completion. The bench drives `qh_new_i` and `xact_done_i` in the same cycle partway through a run. With a count of 1, this gives an immediate advance. With a count of 3, it gives an advance only after two further transactions.

The second pair is a command write together with a completion. The bench lowers or raises the count, or clears the enable, in the same cycle as a `xact_done_i`. It then checks that this completion follows the old settings and the next one follows the new settings.

Expected pulses come from an arithmetic tally kept in the bench across a sweep of enable, count and high-speed settings.

// File: rtl/park_pkg.sv
package park_pkg;

  // Width of the software-visible park count field.
  localparam int unsigned PARK_CNT_W = 2;

  // Count value loaded by reset when the capability strap is set.
  localparam int unsigned PARK_CNT_DEF = 3;

  // Classification of a command write as seen by the configuration register.
  typedef enum logic [1:0] {
    WR_NONE     = 2'd0,  // no write, or strap off
    WR_FULL     = 2'd1,  // enable and count both load
    WR_ENA_ONLY = 2'd2   // count field zero: only the enable loads
  } park_wr_e;

endpackage

// File: rtl/park_cfg.sv
module park_cfg
  import park_pkg::*;
#(
  parameter int unsigned CMD_W   = 16,
  parameter int unsigned ENA_BIT = 11,
  parameter int unsigned CNT_LSB = 8,
  parameter int unsigned CNT_W   = PARK_CNT_W,
  parameter int unsigned CNT_DEF = PARK_CNT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             wr_i,
  input  logic [CMD_W-1:0] wdata_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(CNT_DEF);

  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_field;
  logic             ena_field;
  park_wr_e         wr_kind;

  assign cnt_field = wdata_i[CNT_LSB +: CNT_W];
  assign ena_field = wdata_i[ENA_BIT];

  always_comb begin
    if (!wr_i || !cap_i)        wr_kind = WR_NONE;
    else if (cnt_field == '0)   wr_kind = WR_ENA_ONLY;
    else                        wr_kind = WR_FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= cap_i;
      cnt_q <= cap_i ? CNT_RST : '0;
    end else begin
      unique case (wr_kind)
        WR_FULL: begin
          en_q  <= ena_field;
          cnt_q <= cnt_field;
        end
        WR_ENA_ONLY: en_q <= ena_field;
        default: ;
      endcase
    end
  end

  // Without the strap the fields are read-only zero.
  assign en_o  = cap_i & en_q;
  assign cnt_o = cap_i ? cnt_q : '0;

  // R4
  zero_cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cnt_field == '0) |=> (cnt_o == $past(cnt_o)));

  // R4
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |-> (cnt_o != '0));

  // R2
  strap_off_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && wr_i) |=> (!en_o && cnt_o == '0));

endmodule

// File: rtl/park_run.sv
module park_run #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park_on_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             done_i,
  input  logic             qh_new_i,
  output logic             adv_o
);

  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] base;
  logic [EXT_W-1:0] next_used;
  logic             hit;
  logic             adv_now;
  logic             adv_q;

  // A move to a new head restarts the tally before this cycle's completion.
  assign base      = qh_new_i ? '0 : used_q;
  assign next_used = {1'b0, base} + EXT_W'(1);
  assign hit       = next_used >= {1'b0, limit_i};
  assign adv_now   = done_i && (!park_on_i || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= adv_now;
      if (done_i)        used_q <= adv_now ? '0 : next_used[CNT_W-1:0];
      else if (qh_new_i) used_q <= '0;
    end
  end

  assign adv_o = adv_q;

  // R9
  adv_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> $past(done_i));

  // R5
  no_park_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !park_on_i) |=> adv_o);

  // R6
  limit_one_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && park_on_i && limit_i == CNT_W'(1)) |=> adv_o);

  // R7
  new_head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qh_new_i && !done_i) |=> (used_q == '0));

endmodule

// File: rtl/park_sched_ctrl.sv
module park_sched_ctrl
  import park_pkg::*;
#(
  parameter int unsigned CMD_W   = 16,
  parameter int unsigned ENA_BIT = 11,
  parameter int unsigned CNT_LSB = 8,
  parameter int unsigned CNT_W   = PARK_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park_cap_i,
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             xact_done_i,
  input  logic             qh_hs_i,
  input  logic             qh_new_i,
  output logic             park_en_o,
  output logic [CNT_W-1:0] park_cnt_o,
  output logic             qh_advance_o
);

  logic             en_w;
  logic [CNT_W-1:0] cnt_w;
  logic             park_on;

  park_cfg #(
    .CMD_W  (CMD_W),
    .ENA_BIT(ENA_BIT),
    .CNT_LSB(CNT_LSB),
    .CNT_W  (CNT_W),
    .CNT_DEF(PARK_CNT_DEF)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (park_cap_i),
    .wr_i   (cmd_wr_i),
    .wdata_i(cmd_wdata_i),
    .en_o   (en_w),
    .cnt_o  (cnt_w)
  );

  // Parking only applies to high-speed heads with the mode enabled.
  assign park_on = en_w && qh_hs_i;

  park_run #(
    .CNT_W(CNT_W)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .park_on_i(park_on),
    .limit_i  (cnt_w),
    .done_i   (xact_done_i),
    .qh_new_i (qh_new_i),
    .adv_o    (qh_advance_o)
  );

  assign park_en_o  = en_w;
  assign park_cnt_o = cnt_w;

  // R9
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qh_advance_o && !$past(xact_done_i, 2)) |=> !qh_advance_o || $past(xact_done_i));

endmodule

// File: tb/tb_park_sched_ctrl.sv
`timescale 1ns/1ps
module tb_park_sched_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap = 1'b1;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        done = 1'b0;
  logic        hs = 1'b0;
  logic        qn = 1'b0;
  logic        en_o;
  logic [1:0]  cnt_o;
  logic        adv_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  bit m_en;
  int m_cnt;
  int m_used;

  always #2 clk = ~clk;

  park_sched_ctrl dut (
    .clk(clk), .rst_n(rst_n), .park_cap_i(cap), .cmd_wr_i(wr),
    .cmd_wdata_i(wdata), .xact_done_i(done), .qh_hs_i(hs), .qh_new_i(qn),
    .park_en_o(en_o), .park_cnt_o(cnt_o), .qh_advance_o(adv_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Command word with noise in every unrelated bit.
  function automatic logic [15:0] cmd(bit e, int c);
    logic [15:0] w;
    w = 16'hF4FF;
    w[11] = e;
    w[9:8] = c[1:0];
    return w;
  endfunction

  task automatic do_reset(bit c);
    @(negedge clk);
    cap = c; rst_n = 1'b0; wr = 0; done = 0; qn = 0;
    @(negedge clk);
    rst_n = 1'b1;
    m_en = c; m_cnt = c ? 3 : 0; m_used = 0;
    @(negedge clk);
  endtask

  // One cycle of stimulus, then check the advance and the read-back.
  task automatic step(string req, bit d, bit h, bit n, bit w, logic [15:0] wd);
    int base;
    bit exp;
    bit park;
    done = d; hs = h; qn = n; wr = w; wdata = wd;
    park = cap && m_en && h;
    base = n ? 0 : m_used;
    exp = 0;
    if (d) begin
      if (!park || base + 1 >= m_cnt) begin exp = 1; m_used = 0; end
      else m_used = base + 1;
    end else if (n) m_used = 0;
    if (w && cap) begin
      m_en = wd[11];
      if (wd[9:8] != 0) m_cnt = wd[9:8];
    end
    @(negedge clk);
    done = 0; qn = 0; wr = 0;
    chk(req, adv_o, exp);
    chk(req, en_o, m_en);
    chk(req, cnt_o, m_cnt);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset defaults with strap on
    do_reset(1);
    chk("R1", en_o, 1);
    chk("R1", cnt_o, 3);
    chk("R9", adv_o, 0);

    // R3 R5 R6 sweep of enable, count and speed
    for (int e = 0; e < 2; e++)
      for (int c = 1; c < 4; c++)
        for (int h = 0; h < 2; h++) begin
          step("R3", 0, h[0], 1, 1, cmd(e[0], c));
          for (int k = 0; k < 7; k++) step("R6", 1, h[0], 0, 0, '0);
          for (int k = 0; k < 4; k++) step("R5", k[0], h[0], 0, 0, '0);
          step("R9", 0, h[0], 0, 0, '0);
        end

    // R7 new head mid-run, alone and together with a completion
    for (int c = 1; c < 4; c++) begin
      step("R3", 0, 1, 1, 1, cmd(1, c));
      step("R7", 1, 1, 0, 0, '0);
      step("R7", 0, 1, 1, 0, '0);
      for (int k = 0; k < 3; k++) step("R7", 1, 1, 0, 0, '0);
      step("R7", 1, 1, 1, 0, '0);
      for (int k = 0; k < 3; k++) step("R7", 1, 1, 0, 0, '0);
    end

    // R4 zero count field ignored, enable still applied
    step("R3", 0, 1, 1, 1, cmd(1, 2));
    step("R4", 0, 1, 0, 1, cmd(1, 0));
    step("R4", 0, 1, 0, 1, cmd(0, 0));
    step("R4", 1, 1, 0, 0, '0);
    step("R4", 0, 1, 0, 1, cmd(1, 0));

    // R8 count lowered below transactions already done
    step("R3", 0, 1, 1, 1, cmd(1, 3));
    step("R8", 1, 1, 0, 0, '0);
    step("R8", 1, 1, 0, 0, '0);
    step("R8", 0, 1, 0, 1, cmd(1, 1));
    step("R8", 1, 1, 0, 0, '0);

    // R10 write collides with a completion
    step("R3", 0, 1, 1, 1, cmd(1, 3));
    step("R10", 1, 1, 0, 1, cmd(1, 1));
    step("R10", 1, 1, 0, 0, '0);
    step("R10", 1, 1, 0, 1, cmd(1, 3));
    step("R10", 1, 1, 0, 1, cmd(0, 3));
    step("R10", 1, 1, 0, 0, '0);
    step("R10", 1, 1, 0, 1, cmd(1, 2));
    step("R10", 1, 1, 0, 0, '0);
    step("R10", 1, 1, 0, 0, '0);

    // R2 strap off: read-only zero, every completion advances
    do_reset(0);
    chk("R2", en_o, 0);
    chk("R2", cnt_o, 0);
    step("R2", 0, 1, 1, 1, cmd(1, 3));
    for (int k = 0; k < 4; k++) step("R2", 1, 1, 0, k[0], cmd(1, 2));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule